// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It runs two direction predictors side by side. The first is a per-branch path: low PC bits pick a local history slot, and that slot's recent outcomes index a table of 3-bit counters. The second is a global path: a shift register holding the most recent resolved outcomes indexes a table of 2-bit counters. A third table of 2-bit choice counters, indexed by the same global history, decides which of the two paths supplies the final answer.

The fetch side presents the low PC bits on the lookup port. One cycle later the block returns the final prediction together with both component predictions. The pipeline keeps the component predictions with the branch. When the branch resolves, it sends them back on the update port with the real outcome. The block then trains all three tables and shifts the outcome into both history structures. Updates are assumed to arrive in program order. The block does not repair history after a misprediction and does not predict targets.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, every local counter holds 3'b011, every global counter holds 2'b01, every choice counter holds 2'b01, and all local histories and the global history are zero, so every lookup returns not-taken on all three prediction outputs.
- R2: `predValid` is high in the cycle after a cycle with `lookupValid` high, and low in the cycle after a cycle with `lookupValid` low. `predTaken`, `predLocal` and `predGlobal` in that cycle belong to that lookup.
- R3: The local history slot is `lookupPcLo`. That slot's history value indexes the local counter table, and `predLocal` is the MSB of the selected counter.
- R4: The global history register indexes both the global counter table and the choice table. `predGlobal` is the MSB of the selected global counter. `predTaken` equals `predGlobal` when the MSB of the selected choice counter is 1, and equals `predLocal` when it is 0.
- R5: On each update, every counter that is trained moves up by one on taken and down by one on not-taken. It stops at its all-ones maximum and at zero, and it never wraps.
- R6: On an update, the local counter selected by the slot's history before the update and the global counter selected by the global history before the update are both trained with `updTaken`. The choice counter at that same global index changes only when `updLocalPred` and `updGlobalPred` differ: it moves up when the global prediction matched the outcome and down when the local one did.
- R7: On an update, `updTaken` is shifted into bit 0 of the local history in slot `updPcLo` and into bit 0 of the global history, and the oldest bit of each is dropped.
- R8: A lookup made in the same cycle as an update sees the tables and histories as they were before that update.
- R9: While `updValid` is low, the update inputs have no effect on any table or history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupPcLo | input | SLOT_W | Low PC bits of the branch being fetched |
| updValid | input | 1 | Resolved branch update this cycle |
| updPcLo | input | SLOT_W | Low PC bits of the resolved branch |
| updTaken | input | 1 | Actual outcome, 1 = taken |
| updLocalPred | input | 1 | Local prediction captured at lookup |
| updGlobalPred | input | 1 | Global prediction captured at lookup |
| predValid | output | 1 | Prediction outputs valid |
| predTaken | output | 1 | Final prediction, 1 = taken |
| predLocal | output | 1 | Local component prediction |
| predGlobal | output | 1 | Global component prediction |

## Verification
A bad counter or history bit stays hidden until a lookup reaches that exact entry. A wrong counter then shows on `predLocal` or `predGlobal` one cycle after the lookup. A wrong choice counter shows only when the two component outputs differ, through `predTaken`. A corrupted history bit moves every later lookup that uses it onto a different counter. The result can stay plausible for many branches, so the bench compares every lookup against a reference model of all tables. It sweeps every slot and every history pattern of a small configuration. It also covers saturation at both ends, lookups that collide with updates, and idle cycles with junk on the update inputs.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic wrTables;   // train local and global counters, shift histories
    logic wrChoice;   // train the choice counter
    logic choiceUp;   // direction of the choice step, 1 = toward global
    logic dirTaken;   // resolved direction used for counter steps
    logic selTaken;   // final pick for the current lookup
  } tpStrobe_t;

endpackage

// File: rtl/tp_ctrl.sv
module tp_ctrl
  import tp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      updValid,
  input  logic      updTaken,
  input  logic      updLocalPred,
  input  logic      updGlobalPred,
  input  logic      lkLocal,
  input  logic      lkGlobal,
  input  logic      lkChoice,
  output tpStrobe_t strb
);

  logic compsDisagree;
  logic globalRight;

  always_comb begin
    compsDisagree = updLocalPred ^ updGlobalPred;
    globalRight   = (updGlobalPred == updTaken);
    strb.wrTables = updValid;
    strb.wrChoice = updValid & compsDisagree;
    strb.choiceUp = globalRight;
    strb.dirTaken = updTaken;
    strb.selTaken = lkChoice ? lkGlobal : lkLocal;
  end

  // R9
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |-> !(strb.wrTables || strb.wrChoice));

endmodule

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int SLOT_W  = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpStrobe_t         strb,
  input  logic              lookupValid,
  input  logic [SLOT_W-1:0] lookupPcLo,
  input  logic [SLOT_W-1:0] updPcLo,
  input  logic              updLocalPred,
  input  logic              updGlobalPred,
  output logic              lkLocal,
  output logic              lkGlobal,
  output logic              lkChoice,
  output logic              predValid,
  output logic              predTaken,
  output logic              predLocal,
  output logic              predGlobal
);

  localparam int SLOTS    = 1 << SLOT_W;
  localparam int LENTRIES = 1 << LHIST_W;
  localparam int GENTRIES = 1 << GHIST_W;
  localparam logic [LCTR_W-1:0] LCTR_MAX  = '1;
  localparam logic [LCTR_W-1:0] LCTR_INIT = {1'b0, {(LCTR_W-1){1'b1}}};
  localparam logic [1:0]        CTR_MAX   = 2'b11;
  localparam logic [1:0]        CTR_INIT  = 2'b01;

  logic [LHIST_W-1:0] localHist [SLOTS];
  logic [LCTR_W-1:0]  localCtr  [LENTRIES];
  logic [1:0]         globalCtr [GENTRIES];
  logic [1:0]         choiceCtr [GENTRIES];
  logic [GHIST_W-1:0] ghr;

  // Lookup read path
  logic [LHIST_W-1:0] lkHist;
  always_comb begin
    lkHist   = localHist[lookupPcLo];
    lkLocal  = localCtr[lkHist][LCTR_W-1];
    lkGlobal = globalCtr[ghr][1];
    lkChoice = choiceCtr[ghr][1];
  end

  // Update read-modify path
  logic [LHIST_W-1:0] updHist;
  logic [LCTR_W-1:0]  lcCur, lcNext;
  logic [1:0]         gcCur, gcNext, ccCur, ccNext;

  always_comb begin
    updHist = localHist[updPcLo];
    lcCur   = localCtr[updHist];
    gcCur   = globalCtr[ghr];
    ccCur   = choiceCtr[ghr];

    if (strb.dirTaken) lcNext = (lcCur == LCTR_MAX) ? lcCur : lcCur + 1'b1;
    else               lcNext = (lcCur == '0)       ? lcCur : lcCur - 1'b1;

    if (strb.dirTaken) gcNext = (gcCur == CTR_MAX) ? gcCur : gcCur + 1'b1;
    else               gcNext = (gcCur == 2'b00)   ? gcCur : gcCur - 1'b1;

    if (strb.choiceUp) ccNext = (ccCur == CTR_MAX) ? ccCur : ccCur + 1'b1;
    else               ccNext = (ccCur == 2'b00)   ? ccCur : ccCur - 1'b1;
  end

  // Local tables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SLOTS; i++)    localHist[i] <= '0;
      for (int i = 0; i < LENTRIES; i++) localCtr[i]  <= LCTR_INIT;
    end else if (strb.wrTables) begin
      localCtr[updHist]  <= lcNext;
      localHist[updPcLo] <= {updHist[LHIST_W-2:0], strb.dirTaken};
    end
  end

  // Global and choice tables, global history
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < GENTRIES; i++) begin
        globalCtr[i] <= CTR_INIT;
        choiceCtr[i] <= CTR_INIT;
      end
      ghr <= '0;
    end else begin
      if (strb.wrTables) begin
        globalCtr[ghr] <= gcNext;
        ghr            <= {ghr[GHIST_W-2:0], strb.dirTaken};
      end
      if (strb.wrChoice) choiceCtr[ghr] <= ccNext;
    end
  end

  // Registered prediction outputs
  always_ff @(posedge clk) begin
    if (!rstN) begin
      predValid  <= 1'b0;
      predTaken  <= 1'b0;
      predLocal  <= 1'b0;
      predGlobal <= 1'b0;
    end else begin
      predValid <= lookupValid;
      if (lookupValid) begin
        predTaken  <= strb.selTaken;
        predLocal  <= lkLocal;
        predGlobal <= lkGlobal;
      end
    end
  end

  // R6
  choice_on_disagree_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrChoice |-> (updLocalPred != updGlobalPred));

  // R5
  counter_no_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTables |-> (strb.dirTaken ? (gcNext >= gcCur && lcNext >= lcCur)
                                     : (gcNext <= gcCur && lcNext <= lcCur)));

  // R7
  ghr_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrTables |=> ghr[0] == $past(strb.dirTaken));

  // R4
  agree_pick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (predValid && predLocal == predGlobal) |-> predTaken == predLocal);

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int SLOT_W  = 10,
  parameter int LHIST_W = 10,
  parameter int LCTR_W  = 3,
  parameter int GHIST_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [SLOT_W-1:0] lookupPcLo,
  input  logic              updValid,
  input  logic [SLOT_W-1:0] updPcLo,
  input  logic              updTaken,
  input  logic              updLocalPred,
  input  logic              updGlobalPred,
  output logic              predValid,
  output logic              predTaken,
  output logic              predLocal,
  output logic              predGlobal
);

  tpStrobe_t strb;
  logic      lkLocal, lkGlobal, lkChoice;

  tp_ctrl i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .updValid      (updValid),
    .updTaken      (updTaken),
    .updLocalPred  (updLocalPred),
    .updGlobalPred (updGlobalPred),
    .lkLocal       (lkLocal),
    .lkGlobal      (lkGlobal),
    .lkChoice      (lkChoice),
    .strb          (strb)
  );

  tp_datapath #(
    .SLOT_W  (SLOT_W),
    .LHIST_W (LHIST_W),
    .LCTR_W  (LCTR_W),
    .GHIST_W (GHIST_W)
  ) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .lookupValid   (lookupValid),
    .lookupPcLo    (lookupPcLo),
    .updPcLo       (updPcLo),
    .updLocalPred  (updLocalPred),
    .updGlobalPred (updGlobalPred),
    .lkLocal       (lkLocal),
    .lkGlobal      (lkGlobal),
    .lkChoice      (lkChoice),
    .predValid     (predValid),
    .predTaken     (predTaken),
    .predLocal     (predLocal),
    .predGlobal    (predGlobal)
  );

endmodule

// File: tb/test_tourney_predictor.sv
module test_tourney_predictor;

  localparam int SLOT_W  = 3;
  localparam int LHIST_W = 3;
  localparam int LCTR_W  = 3;
  localparam int GHIST_W = 4;
  localparam int SLOTS    = 1 << SLOT_W;
  localparam int LENTRIES = 1 << LHIST_W;
  localparam int GENTRIES = 1 << GHIST_W;
  localparam int LMAX     = (1 << LCTR_W) - 1;

  logic              clk = 1'b0;
  logic              rstN;
  logic              lookupValid;
  logic [SLOT_W-1:0] lookupPcLo;
  logic              updValid;
  logic [SLOT_W-1:0] updPcLo;
  logic              updTaken;
  logic              updLocalPred;
  logic              updGlobalPred;
  logic              predValid, predTaken, predLocal, predGlobal;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tourney_predictor #(
    .SLOT_W (SLOT_W), .LHIST_W (LHIST_W), .LCTR_W (LCTR_W), .GHIST_W (GHIST_W)
  ) i_tourney_predictor (
    .clk (clk), .rstN (rstN),
    .lookupValid (lookupValid), .lookupPcLo (lookupPcLo),
    .updValid (updValid), .updPcLo (updPcLo), .updTaken (updTaken),
    .updLocalPred (updLocalPred), .updGlobalPred (updGlobalPred),
    .predValid (predValid), .predTaken (predTaken),
    .predLocal (predLocal), .predGlobal (predGlobal)
  );

  // Reference model state
  int mHist [SLOTS];
  int mLctr [LENTRIES];
  int mGctr [GENTRIES];
  int mCctr [GENTRIES];
  int mGhr;
  logic [15:0] lfsr = 16'hACE1;

  function automatic int stepCtr(int cur, bit up, int maxv);
    if (up) return (cur == maxv) ? cur : cur + 1;
    return (cur == 0) ? cur : cur - 1;
  endfunction

  function automatic bit expLocal(int slot);
    return mLctr[mHist[slot]] >= (LMAX + 1) / 2;  // R3: MSB of 3-bit counter
  endfunction
  function automatic bit expGlobal();
    return mGctr[mGhr] >= 2;                      // R4: MSB of 2-bit counter
  endfunction
  function automatic bit expTaken(int slot);
    return (mCctr[mGhr] >= 2) ? expGlobal() : expLocal(slot);
  endfunction

  task automatic modelReset();
    for (int i = 0; i < SLOTS; i++)    mHist[i] = 0;
    for (int i = 0; i < LENTRIES; i++) mLctr[i] = 3;
    for (int i = 0; i < GENTRIES; i++) begin mGctr[i] = 1; mCctr[i] = 1; end
    mGhr = 0;
  endtask

  // R5 R6 R7 reference training
  task automatic modelUpdate(int slot, bit tk, bit lp, bit gp);
    int h;
    h = mHist[slot];
    mLctr[h] = stepCtr(mLctr[h], tk, LMAX);
    mGctr[mGhr] = stepCtr(mGctr[mGhr], tk, 3);
    if (lp != gp) mCctr[mGhr] = stepCtr(mCctr[mGhr], gp == tk, 3);
    mHist[slot] = ((h << 1) | int'(tk)) & (LENTRIES - 1);
    mGhr = ((mGhr << 1) | int'(tk)) & (GENTRIES - 1);
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic nextRand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Compare the registered outputs of one lookup against the model
  task automatic cmpPred(int slot, bit eL, bit eG, bit eT, string req);
    chk(predValid == 1'b1, "R2", "predValid", int'(predValid), 1);
    chk(predLocal == eL,  req, "predLocal",  int'(predLocal),  int'(eL));
    chk(predGlobal == eG, req, "predGlobal", int'(predGlobal), int'(eG));
    chk(predTaken == eT,  req, "predTaken",  int'(predTaken),  int'(eT));
  endtask

  task automatic doLookup(int slot, string req);
    bit eL, eG, eT;
    eL = expLocal(slot); eG = expGlobal(); eT = expTaken(slot);
    @(negedge clk);
    lookupValid = 1'b1; lookupPcLo = SLOT_W'(slot);
    @(negedge clk);
    lookupValid = 1'b0;
    cmpPred(slot, eL, eG, eT, req);
  endtask

  task automatic doUpdate(int slot, bit tk);
    bit lp, gp;
    lp = expLocal(slot); gp = expGlobal();
    @(negedge clk);
    updValid = 1'b1; updPcLo = SLOT_W'(slot); updTaken = tk;
    updLocalPred = lp; updGlobalPred = gp;
    @(negedge clk);
    updValid = 1'b0;
    modelUpdate(slot, tk, lp, gp);
  endtask

  task automatic lookupAndTrain(int slot, bit tk, string req);
    doLookup(slot, req);
    doUpdate(slot, tk);
  endtask

  // R8: lookup and update in the same cycle
  task automatic doBoth(int lkSlot, int upSlot, bit tk);
    bit eL, eG, eT, lp, gp;
    eL = expLocal(lkSlot); eG = expGlobal(); eT = expTaken(lkSlot);
    lp = expLocal(upSlot); gp = expGlobal();
    @(negedge clk);
    lookupValid = 1'b1; lookupPcLo = SLOT_W'(lkSlot);
    updValid = 1'b1; updPcLo = SLOT_W'(upSlot); updTaken = tk;
    updLocalPred = lp; updGlobalPred = gp;
    @(negedge clk);
    lookupValid = 1'b0; updValid = 1'b0;
    modelUpdate(upSlot, tk, lp, gp);
    cmpPred(lkSlot, eL, eG, eT, "R8");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; lookupValid = 1'b0; lookupPcLo = '0;
    updValid = 1'b0; updPcLo = '0; updTaken = 1'b0;
    updLocalPred = 1'b0; updGlobalPred = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state, every slot predicts not-taken
    @(negedge clk);
    chk(predValid == 1'b0, "R2", "predValid idle", int'(predValid), 0);
    for (int s = 0; s < SLOTS; s++) begin
      doLookup(s, "R1");
      chk({predTaken, predLocal, predGlobal} == 3'b000, "R1", "reset preds",
          int'({predTaken, predLocal, predGlobal}), 0);
    end
    @(negedge clk);
    chk(predValid == 1'b0, "R2", "predValid after lookup", int'(predValid), 0);

    // R5: saturate upward then downward on one branch
    for (int i = 0; i < 12; i++) lookupAndTrain(5, 1'b1, "R5");
    for (int i = 0; i < 14; i++) lookupAndTrain(5, 1'b0, "R5");
    for (int i = 0; i < 12; i++) lookupAndTrain(5, 1'b1, "R5");

    // R3: alternating outcome on one branch favours the local path
    for (int i = 0; i < 48; i++) lookupAndTrain(2, i[0], "R3");

    // R4 R6: outcome correlated with global history
    for (int i = 0; i < 400; i++) begin
      nextRand();
      lookupAndTrain(int'(lfsr[2:0]), bit'(mGhr[0] ^ mGhr[1]), "R4");
    end

    // R6 R7: random branches, every slot and history visited
    for (int i = 0; i < 800; i++) begin
      nextRand();
      lookupAndTrain(int'(lfsr[2:0]), lfsr[7] | lfsr[9], "R6");
    end
    for (int i = 0; i < 200; i++) begin
      nextRand();
      lookupAndTrain(int'(lfsr[5:3]), lfsr[4] ^ (int'(lfsr[5:3]) == 1), "R7");
    end

    // R8: collisions between lookup and update
    for (int i = 0; i < 200; i++) begin
      nextRand();
      doBoth(int'(lfsr[2:0]), (i % 4 == 0) ? int'(lfsr[2:0]) : int'(lfsr[6:4]),
             lfsr[11]);
    end

    // R9: junk on update inputs with updValid low
    for (int i = 0; i < 40; i++) begin
      nextRand();
      @(negedge clk);
      updValid = 1'b0; updPcLo = lfsr[2:0]; updTaken = lfsr[3];
      updLocalPred = lfsr[4]; updGlobalPred = lfsr[5];
    end
    for (int s = 0; s < SLOTS; s++) doLookup(s, "R9");

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule